// File: doc/BRIEF.md
# Multi-cycle shared-bus processor

This block is a tiny processor core built around a single 16-bit bus. Eight general registers, an operand latch, a result latch and the input port all reach one another only through that bus. A one-hot source multiplexer picks which of them drives it. A 2-bit step counter walks each instruction through a fetch step and up to three execute steps. In each step the control logic names one bus source and one destination to load.

The surrounding logic feeds instructions and immediate words on `din` and holds `run` high while it wants work done. The instruction word is captured from the top nine bits of `din` in the fetch step. For a move-immediate, the data word follows on `din` in the next cycle. `done` pulses in the last step of every instruction, and the bus value is visible on `bus_out` so results can be observed.

Top module: `bus_cpu`

## Requirements
- R1: A synchronous active-high `rst` returns the step counter to fetch and clears R0 to R7, the operand latch and the result latch to zero. `done` is low afterwards and `bus_out` reads zero while no source is selected.
- R2: While `run` is low in the fetch step, nothing is captured, no register is written, the step counter stays at fetch, `done` stays low and `bus_out` reads zero.
- R3: The instruction is `din[15:7]`, laid out as opcode in bits 8:6, destination index Rx in bits 5:3 and source index Ry in bits 2:0. `din[6:0]` has no effect on the fetched instruction.
- R4: Opcode 000 (move) puts Ry on the bus in the cycle after the fetch edge, loads Rx from it and raises `done` in that cycle.
- R5: Opcode 001 (move immediate) puts the word present on `din` in the cycle after the fetch edge onto the bus, loads Rx from it and raises `done` in that cycle.
- R6: Opcode 010 (add) takes three execute cycles: Rx to the operand latch, then result latch = operand + Ry, then result latch to Rx. In the third cycle `done` is high and `bus_out` equals (Rx + Ry) mod 2^16.
- R7: Opcode 011 (subtract) behaves like add with result (Rx - Ry) mod 2^16.
- R8: Opcodes 100 to 111 write no register, leave `bus_out` at zero, and raise `done` in the cycle after the fetch edge.
- R9: `done` lasts exactly one cycle, and the step after `done` is a fetch step, so a new instruction can be captured immediately.
- R10: Once an instruction is fetched it runs to completion whatever `run` does, and the step counter advances by one each execute cycle.
- R11: At most one bus source is selected in any cycle. With none selected, the bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Permits an instruction fetch in the fetch step |
| din | input | 16 | Instruction word (upper nine bits) or immediate data |
| done | output | 1 | One-cycle pulse in the final step of an instruction |
| bus_out | output | 16 | Current value on the shared bus |

## Verification
The bench builds the block with its default 16-bit data width and eight registers. With these values, every 3-bit register index in both operand fields can be reached as source and destination, including an instruction that names the same register twice. The 16-bit width puts the add carry-out wrap (FFFF + 3) and the subtract borrow (3 - 5, 8000 - 2) within a short program. The fixed 9-bit instruction field in the top of the 16-bit input also leaves seven low bits that the bench fills with a nonzero pattern, to show they are ignored.

// File: rtl/bus_cpu_pkg.sv
package bus_cpu_pkg;

    localparam int DATA_W  = 16;
    localparam int REG_CNT = 8;
    localparam int SEL_W   = $clog2(REG_CNT);
    localparam int OP_W    = 3;
    localparam int INSTR_W = OP_W + 2 * SEL_W;
    localparam int STEP_W  = 2;

    localparam logic [OP_W-1:0] OPC_MOVE = 3'b000;
    localparam logic [OP_W-1:0] OPC_MVI  = 3'b001;
    localparam logic [OP_W-1:0] OPC_ADD  = 3'b010;
    localparam logic [OP_W-1:0] OPC_SUB  = 3'b011;

    typedef enum logic [STEP_W-1:0] {
        STEP_FETCH = 2'd0,
        STEP_X1    = 2'd1,
        STEP_X2    = 2'd2,
        STEP_X3    = 2'd3
    } step_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [SEL_W-1:0] rx;
        logic [SEL_W-1:0] ry;
    } instr_t;

    typedef struct packed {
        logic               ir_ld;
        logic               a_ld;
        logic               g_ld;
        logic               subtract;
        logic [REG_CNT-1:0] reg_ld;
        logic [REG_CNT-1:0] src_reg;
        logic               src_g;
        logic               src_din;
        logic               done;
        logic               restart;
    } ctrl_t;

    function automatic logic [REG_CNT-1:0] sel_onehot(input logic [SEL_W-1:0] idx);
        logic [REG_CNT-1:0] v;
        v      = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic logic is_arith(input logic [OP_W-1:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

endpackage

// File: rtl/bus_cpu_reg.sv
module bus_cpu_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bus_cpu_alu.sv
module bus_cpu_alu #(
    parameter int W = 16
) (
    input  logic         subtract,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] result
);

    always_comb begin
        if (subtract) begin
            result = lhs - rhs;
        end else begin
            result = lhs + rhs;
        end
    end

endmodule

// File: rtl/bus_cpu_mux.sv
module bus_cpu_mux #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic [N-1:0][W-1:0] regs,
    input  logic [W-1:0]        g_val,
    input  logic [W-1:0]        din,
    input  logic [N-1:0]        src_reg,
    input  logic                src_g,
    input  logic                src_din,
    output logic [W-1:0]        bus
);

    // One-hot selects: an AND-OR tree, no priority chain.
    always_comb begin
        bus = ({W{src_g}} & g_val) | ({W{src_din}} & din);
        for (int i = 0; i < N; i++) begin
            bus = bus | ({W{src_reg[i]}} & regs[i]);
        end
    end

endmodule

// File: rtl/bus_cpu_ctrl.sv
module bus_cpu_ctrl
    import bus_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  instr_t ir,
    output ctrl_t  ctl,
    output step_e  step
);

    step_e step_q;
    step_e step_d;

    always_comb begin
        ctl = '0;
        unique case (step_q)
            STEP_FETCH: begin
                ctl.ir_ld = run;
            end
            STEP_X1: begin
                if (ir.op == OPC_MOVE) begin
                    ctl.src_reg = sel_onehot(ir.ry);
                    ctl.reg_ld  = sel_onehot(ir.rx);
                    ctl.done    = 1'b1;
                    ctl.restart = 1'b1;
                end else if (ir.op == OPC_MVI) begin
                    ctl.src_din = 1'b1;
                    ctl.reg_ld  = sel_onehot(ir.rx);
                    ctl.done    = 1'b1;
                    ctl.restart = 1'b1;
                end else if (is_arith(ir.op)) begin
                    ctl.src_reg = sel_onehot(ir.rx);
                    ctl.a_ld    = 1'b1;
                end else begin
                    ctl.done    = 1'b1;
                    ctl.restart = 1'b1;
                end
            end
            STEP_X2: begin
                ctl.src_reg  = sel_onehot(ir.ry);
                ctl.g_ld     = 1'b1;
                ctl.subtract = (ir.op == OPC_SUB);
            end
            STEP_X3: begin
                ctl.src_g   = 1'b1;
                ctl.reg_ld  = sel_onehot(ir.rx);
                ctl.done    = 1'b1;
                ctl.restart = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    always_comb begin
        if (ctl.restart) begin
            step_d = STEP_FETCH;
        end else if ((step_q == STEP_FETCH) && !run) begin
            step_d = STEP_FETCH;
        end else begin
            step_d = step_e'(step_q + 2'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= STEP_FETCH;
        end else begin
            step_q <= step_d;
        end
    end

    assign step = step_q;

endmodule

// File: rtl/bus_cpu.sv
module bus_cpu
    import bus_cpu_pkg::*;
#(
    parameter int DW = bus_cpu_pkg::DATA_W,
    parameter int NR = bus_cpu_pkg::REG_CNT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] din,
    output logic          done,
    output logic [DW-1:0] bus_out
);

    localparam int IR_LSB = DW - INSTR_W;

    ctrl_t                 ctl;
    step_e                 step;
    instr_t                ir_q;
    logic [DW-1:0]         bus;
    logic [DW-1:0]         a_q;
    logic [DW-1:0]         g_q;
    logic [DW-1:0]         sum;
    logic [NR-1:0][DW-1:0] regs;

    bus_cpu_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .ir   (ir_q),
        .ctl  (ctl),
        .step (step)
    );

    bus_cpu_reg #(.W(INSTR_W)) u_ir (
        .clk (clk),
        .rst (rst),
        .ld  (ctl.ir_ld),
        .d   (din[DW-1:IR_LSB]),
        .q   (ir_q)
    );

    generate
        for (genvar r = 0; r < NR; r++) begin : g_gpr
            bus_cpu_reg #(.W(DW)) u_gpr (
                .clk (clk),
                .rst (rst),
                .ld  (ctl.reg_ld[r]),
                .d   (bus),
                .q   (regs[r])
            );
        end
    endgenerate

    bus_cpu_reg #(.W(DW)) u_a (
        .clk (clk),
        .rst (rst),
        .ld  (ctl.a_ld),
        .d   (bus),
        .q   (a_q)
    );

    bus_cpu_alu #(.W(DW)) u_alu (
        .subtract (ctl.subtract),
        .lhs      (a_q),
        .rhs      (bus),
        .result   (sum)
    );

    bus_cpu_reg #(.W(DW)) u_g (
        .clk (clk),
        .rst (rst),
        .ld  (ctl.g_ld),
        .d   (sum),
        .q   (g_q)
    );

    bus_cpu_mux #(.W(DW), .N(NR)) u_mux (
        .regs    (regs),
        .g_val   (g_q),
        .din     (din),
        .src_reg (ctl.src_reg),
        .src_g   (ctl.src_g),
        .src_din (ctl.src_din),
        .bus     (bus)
    );

    assign done    = ctl.done;
    assign bus_out = bus;

endmodule

// File: rtl/bus_cpu_chk.sv
module bus_cpu_chk
    import bus_cpu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic               done,
    input logic [STEP_W-1:0]  step,
    input logic [OP_W-1:0]    op,
    input logic [REG_CNT+1:0] src_sel
);

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (step == 2'd0 && !done));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step == 2'd0 && !run) |=> (step == 2'd0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_refetch_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (step == 2'd0));

    // R10
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step != 2'd0 && !done) |=> (step == $past(step) + 2'd1));

    // R6
    arith_no_early_done_chk: assert property (@(posedge clk) disable iff (rst)
        (step == 2'd1 && is_arith(op)) |-> !done);

    // R6
    last_step_done_chk: assert property (@(posedge clk) disable iff (rst)
        (step == 2'd3) |-> done);

    // R8
    short_op_done_chk: assert property (@(posedge clk) disable iff (rst)
        (step == 2'd1 && !is_arith(op)) |-> done);

    // R11
    bus_src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_sel));

endmodule

bind bus_cpu bus_cpu_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .done    (done),
    .step    (step),
    .op      (ir_q.op),
    .src_sel ({ctl.src_reg, ctl.src_g, ctl.src_din})
);

// File: tb/bus_cpu_test.sv
module bus_cpu_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] din = '0;
    logic        done;
    logic [15:0] bus_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    bus_cpu uut (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .din     (din),
        .done    (done),
        .bus_out (bus_out)
    );

    always #5 clk = ~clk;

    // entry: op(3) rx(3) ry(3) imm(16) expected bus at done(16) execute steps(2)
    localparam int NPROG = 19;
    localparam logic [42:0] PROG [NPROG] = '{
        {3'd1, 3'd0, 3'd0, 16'h0005, 16'h0005, 2'd1},  // mvi R0,5
        {3'd1, 3'd1, 3'd0, 16'h0003, 16'h0003, 2'd1},  // mvi R1,3
        {3'd2, 3'd0, 3'd1, 16'h0000, 16'h0008, 2'd3},  // add R0,R1
        {3'd3, 3'd0, 3'd1, 16'h0000, 16'h0005, 2'd3},  // sub R0,R1
        {3'd0, 3'd2, 3'd0, 16'h0000, 16'h0005, 2'd1},  // mv R2,R0
        {3'd1, 3'd7, 3'd0, 16'hFFFF, 16'hFFFF, 2'd1},  // mvi R7,FFFF
        {3'd2, 3'd7, 3'd1, 16'h0000, 16'h0002, 2'd3},  // add wraps
        {3'd3, 3'd1, 3'd0, 16'h0000, 16'hFFFE, 2'd3},  // sub borrows
        {3'd0, 3'd3, 3'd3, 16'h0000, 16'h0000, 2'd1},  // R3 untouched
        {3'd2, 3'd2, 3'd2, 16'h0000, 16'h000A, 2'd3},  // add R2,R2
        {3'd1, 3'd5, 3'd0, 16'h8000, 16'h8000, 2'd1},  // mvi R5,8000
        {3'd3, 3'd5, 3'd7, 16'h0000, 16'h7FFE, 2'd3},  // sub R5,R7
        {3'd0, 3'd6, 3'd5, 16'h0000, 16'h7FFE, 2'd1},  // mv R6,R5
        {3'd4, 3'd2, 3'd2, 16'hBEEF, 16'h0000, 2'd1},  // unused opcode
        {3'd0, 3'd2, 3'd2, 16'h0000, 16'h000A, 2'd1},  // R2 kept
        {3'd7, 3'd6, 3'd1, 16'hBEEF, 16'h0000, 2'd1},  // unused opcode
        {3'd0, 3'd6, 3'd6, 16'h0000, 16'h7FFE, 2'd1},  // R6 kept
        {3'd0, 3'd4, 3'd1, 16'h0000, 16'hFFFE, 2'd1},  // mv R4,R1
        {3'd0, 3'd1, 3'd1, 16'h0000, 16'hFFFE, 2'd1}   // source kept
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0:    return "R4";
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R7";
            default: return "R8";
        endcase
    endfunction

    // Starts just after a rising edge, with the design in its fetch step.
    task automatic run_op(input logic [2:0] op, input logic [2:0] rx, input logic [2:0] ry,
                          input logic [15:0] imm, input logic [15:0] exp,
                          input int steps, input bit drop_run);
        int n;
        din = {op, rx, ry, 7'h55};  // R3: low bits carry junk
        run = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R9", "done in fetch step", {15'd0, done}, 16'd0);
        @(posedge clk);
        #1;
        din = imm;
        if (drop_run) run = 1'b0;
        n = 1;
        @(negedge clk);
        while (!done && n < 8) begin
            @(posedge clk);
            #1;
            @(negedge clk);
            n++;
        end
        check(bus_out == exp, {op_tag(op), "/R3"}, "bus at done", bus_out, exp);
        check(n == steps, {op_tag(op), "/R9"}, "execute steps", 16'(n), 16'(steps));
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL R9 watchdog: actual %0d cycles expected under %0d", cycles, 50000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", {15'd0, done}, 16'd0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", {15'd0, done}, 16'd0);
        check(bus_out == 16'h0, "R1", "bus after reset", bus_out, 16'h0);
        @(posedge clk);
        #1;

        for (int i = 0; i < NPROG; i++) begin
            run_op(PROG[i][42:40], PROG[i][39:37], PROG[i][36:34], PROG[i][33:18],
                   PROG[i][17:2], int'(PROG[i][1:0]), 1'b0);
        end

        // R2: run low, a move-immediate to R4 sits on din and must not execute
        run = 1'b0;
        din = {3'd1, 3'd4, 3'd0, 7'h00};
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(done == 1'b0, "R2", "done while idle", {15'd0, done}, 16'd0);
            check(bus_out == 16'h0, "R2", "bus while idle", bus_out, 16'h0);
            @(posedge clk);
            #1;
            din = 16'h1234;
        end
        run_op(3'd0, 3'd4, 3'd4, 16'h0, 16'hFFFE, 1, 1'b0);  // R2: R4 unchanged

        // R10: run dropped right after fetch; add R6,R1 = 7FFE + FFFE
        run_op(3'd2, 3'd6, 3'd1, 16'h0, 16'h7FFC, 3, 1'b1);

        // R1: reset in the middle of an add
        din = {3'd2, 3'd0, 3'd1, 7'h00};
        run = 1'b1;
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        rst = 1'b1;
        run = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after mid reset", {15'd0, done}, 16'd0);
        check(bus_out == 16'h0, "R1", "bus after mid reset", bus_out, 16'h0);
        @(posedge clk);
        #1;
        run_op(3'd0, 3'd0, 3'd0, 16'h0, 16'h0000, 1, 1'b0);  // R1: R0 cleared
        run_op(3'd0, 3'd6, 3'd6, 16'h0, 16'h0000, 1, 1'b0);  // R1: R6 cleared

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule